// File: doc/BRIEF.md
# Dual-Channel Five-Sample Moving Average

This block smooths two independent streams of signed 14-bit samples. Both channels are clocked by the same clock and can take a new sample on every cycle. Each channel keeps its own record of the four samples before the current one. It produces the equal-weight mean of the current sample and those four.

The weight of one fifth is a 16-bit fixed-point constant, 13107/65536. The full-precision product is cut down to a 16-bit signed result that has the input scale plus two extra fractional bits, so each result equals sum*13107/16384. The cut uses round-half-to-even and clamps to the signed 16-bit range.

An input-valid strobe qualifies every sample pair. A cycle without it leaves the filter state untouched. Each accepted pair gives exactly one result pair, flagged by an output-valid strobe three clock edges later. Between valid results the outputs hold their last value.

Top module: `dual_mean5_filter`

## Requirements
- R1: A synchronous active-high reset clears the sample history of both channels, both outputs to 0 and the output-valid strobe to 0.
- R2: When `inValid` is high before clock edge k, `outValid` is high after edge k+2, and only then (latency of three edges).
- R3: Each valid result equals round(S*13107/16384), where S is the sum of the current sample and the four previously accepted samples of that channel. The result is a 16-bit two's complement value.
- R4: A remainder of exactly one half (the low 14 bits of S*13107 equal 8192) rounds to the even neighbour.
- R5: Channel B is computed from its own samples and history only, in the same cycle as channel A, and is never influenced by channel A.
- R6: A sample presented while `inValid` is low is ignored. It neither enters the history nor produces a result.
- R7: While `outValid` is low, both outputs keep the value of the last valid result (0 after reset).
- R8: Results are clamped to [-32768, 32767]. Five samples of -8192 give -32768, and five samples of 8191 give 32764.
- R9: After reset the history is zero, so the first four results after reset include zero terms for the missing samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per channel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies the sample pair on `inA`/`inB` |
| inA | input | 14 | Channel A sample, two's complement |
| inB | input | 14 | Channel B sample, two's complement |
| outValid | output | 1 | High when `outA`/`outB` carry a new result |
| outA | output | 16 | Channel A mean, two extra fractional bits |
| outB | output | 16 | Channel B mean, two extra fractional bits |

## Verification
Two functions can fall in the same cycle: a valid result leaving the pipeline, and an input gap that must freeze the history while the older samples are still in flight. The bench provokes this with pseudo-random gap patterns over random samples. Each output is judged against an arithmetic model that applies only accepted samples and holds the last result during gaps. A long ramp on both channels, with channel B mirrored against channel A, reaches rounding ties in both directions. Extreme constant runs and a reset in the middle of a stream cover the clamp edge and the zero history.

// File: rtl/avg5_pkg.sv
package avg5_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shiftEn;  // accept sample: shift history, load tap sum
    logic prodEn;   // load scaled product
    logic outEn;    // load rounded result
  } avgCtrl_t;
endpackage

// File: rtl/avg5_ctrl.sv
module avg5_ctrl
  import avg5_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output avgCtrl_t ctrl,
  output logic     outValid
);
  logic sumValid;
  logic prodValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      sumValid  <= 1'b0;
      prodValid <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      sumValid  <= inValid;
      prodValid <= sumValid;
      outValid  <= prodValid;
    end
  end

  always_comb begin
    ctrl.shiftEn = inValid;
    ctrl.prodEn  = sumValid;
    ctrl.outEn   = prodValid;
  end
endmodule

// File: rtl/avg5_datapath.sv
module avg5_datapath
  import avg5_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int SAMPLE_W = 14,
  parameter int OUT_W    = 16,
  parameter int TAPS     = 5,
  parameter int COEF_W   = 16,
  parameter int COEF     = 13107,
  parameter int EXTRA_FR = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  avgCtrl_t                  ctrl,
  input  logic [NCH*SAMPLE_W-1:0]   inSamples,
  output logic [NCH*OUT_W-1:0]      outSamples
);
  localparam int SUM_W  = SAMPLE_W + $clog2(TAPS);
  localparam int PROD_W = SUM_W + COEF_W + 1;
  localparam int DROP   = COEF_W - EXTRA_FR;
  localparam int HIST   = TAPS - 1;
  localparam logic signed [PROD_W-1:0] OUT_MAX = PROD_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] OUT_MIN = -OUT_MAX - PROD_W'(1);
  localparam logic signed [PROD_W-1:0] COEF_S  = PROD_W'(COEF);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic signed [SAMPLE_W-1:0] sample;
    logic signed [SAMPLE_W-1:0] hist [HIST];
    logic signed [SUM_W-1:0]    sumNext, sumQ;
    logic signed [PROD_W-1:0]   prodNext, prodQ;
    logic signed [PROD_W-1:0]   floorQ, rounded;
    logic [DROP-1:0]            rem;
    logic                       roundUp;
    logic signed [OUT_W-1:0]    resNext, resQ;

    assign sample = inSamples[ch*SAMPLE_W +: SAMPLE_W];

    // Sum of the current sample and the history
    always_comb begin
      sumNext = SUM_W'(sample);
      for (int t = 0; t < HIST; t++) begin
        sumNext = sumNext + SUM_W'(hist[t]);
      end
    end

    // Full-precision scaling, then round-half-to-even and clamp
    assign prodNext = PROD_W'(sumQ) * COEF_S;
    assign floorQ   = prodQ >>> DROP;
    assign rem      = prodQ[DROP-1:0];
    assign roundUp  = rem[DROP-1] && ((|rem[DROP-2:0]) || floorQ[0]);
    assign rounded  = floorQ + PROD_W'(roundUp);

    always_comb begin
      if (rounded > OUT_MAX)      resNext = OUT_W'(OUT_MAX);
      else if (rounded < OUT_MIN) resNext = OUT_W'(OUT_MIN);
      else                        resNext = OUT_W'(rounded);
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int t = 0; t < HIST; t++) hist[t] <= '0;
        sumQ  <= '0;
        prodQ <= '0;
        resQ  <= '0;
      end else begin
        if (ctrl.shiftEn) begin
          hist[0] <= sample;
          for (int t = 1; t < HIST; t++) hist[t] <= hist[t-1];
          sumQ <= sumNext;
        end
        if (ctrl.prodEn) prodQ <= prodNext;
        if (ctrl.outEn)  resQ  <= resNext;
      end
    end

    assign outSamples[ch*OUT_W +: OUT_W] = resQ;
  end
endmodule

// File: rtl/dual_mean5_filter.sv
module dual_mean5_filter
  import avg5_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [13:0] inA,
  input  logic [13:0] inB,
  output logic        outValid,
  output logic [15:0] outA,
  output logic [15:0] outB
);
  avgCtrl_t    ctrl;
  logic [31:0] outPacked;

  avg5_ctrl i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  avg5_datapath #(
    .NCH      (2),
    .SAMPLE_W (14),
    .OUT_W    (16)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .inSamples  ({inB, inA}),
    .outSamples (outPacked)
  );

  assign outA = outPacked[15:0];
  assign outB = outPacked[31:16];
endmodule

// File: rtl/avg5_checker.sv
module avg5_checker (
  input logic        clk,
  input logic        rst,
  input logic        inValid,
  input logic        outValid,
  input logic [15:0] outA,
  input logic [15:0] outB
);
  logic [2:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else     seen <= {seen[1:0], inValid};
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!outValid && outA == 16'd0 && outB == 16'd0));

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    outValid == seen[2]);

  assert_hold_a_R7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outA));

  assert_hold_b_R7: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outB));
endmodule

bind dual_mean5_filter avg5_checker u_avg5_checker (.*);

// File: tb/test_dual_mean5_filter.sv
module test_dual_mean5_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [13:0] inA = '0;
  logic [13:0] inB = '0;
  logic        outValid;
  logic [15:0] outA, outB;

  int total = 0;
  int bad   = 0;

  // bench model
  longint histA [4];
  longint histB [4];
  bit     pV [3];
  longint pA [3], pB [3];
  int     pTagA [3], pTagB [3];
  longint heldA = 0, heldB = 0;
  int     nAcc = 0;
  bit     gapSeen = 0;

  always #5 clk = ~clk;

  dual_mean5_filter i_dual_mean5_filter (
    .clk(clk), .rst(rst), .inValid(inValid), .inA(inA), .inB(inB),
    .outValid(outValid), .outA(outA), .outB(outB)
  );

  function automatic longint roundRes(longint s, output bit tie);
    longint p, q, r;
    p = s * 13107;
    q = p >>> 14;
    r = p - (q <<< 14);
    tie = (r == 8192);
    if (r > 8192 || (r == 8192 && q[0])) q = q + 1;
    if (q > 32767)  q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string tagName(int t);
    case (t)
      1: return "R4";
      2: return "R9";
      3: return "R6";
      4: return "R8";
      5: return "R5";
      default: return "R3";
    endcase
  endfunction

  task automatic modelClear();
    for (int i = 0; i < 4; i++) begin histA[i] = 0; histB[i] = 0; end
    for (int i = 0; i < 3; i++) pV[i] = 0;
    heldA = 0; heldB = 0; nAcc = 0; gapSeen = 0;
  endtask

  // one cycle: check outputs, advance model, drive new inputs
  task automatic step(int a, int b, bit v, bit doCheck = 1);
    longint sA, sB, eA, eB;
    bit tA, tB;
    int tgA, tgB;
    @(negedge clk);
    if (doCheck) begin
      check("R2 outValid", outValid, pV[2]);
      if (pV[2]) begin
        heldA = pA[2]; heldB = pB[2];
        check(tagName(pTagA[2]), $signed(outA), pA[2]);
        check(tagName(pTagB[2]), $signed(outB), pB[2]);
      end else begin
        check("R7 hold A", $signed(outA), heldA);
        check("R7 hold B", $signed(outB), heldB);
      end
    end
    pV[2] = pV[1]; pA[2] = pA[1]; pB[2] = pB[1]; pTagA[2] = pTagA[1]; pTagB[2] = pTagB[1];
    pV[1] = pV[0]; pA[1] = pA[0]; pB[1] = pB[0]; pTagA[1] = pTagA[0]; pTagB[1] = pTagB[0];
    pV[0] = v && !rst;
    if (v && !rst) begin
      sA = a; sB = b;
      for (int i = 0; i < 4; i++) begin sA += histA[i]; sB += histB[i]; end
      eA = roundRes(sA, tA);
      eB = roundRes(sB, tB);
      tgA = 0;
      if (sA == -40960 || sA == 40955) tgA = 4;
      else if (tA) tgA = 1;
      else if (nAcc < 4) tgA = 2;
      else if (gapSeen) tgA = 3;
      tgB = 5;
      if (sB == -40960 || sB == 40955) tgB = 4;
      else if (tB) tgB = 1;
      pA[0] = eA; pB[0] = eB; pTagA[0] = tgA; pTagB[0] = tgB;
      for (int i = 3; i > 0; i--) begin histA[i] = histA[i-1]; histB[i] = histB[i-1]; end
      histA[0] = a; histB[0] = b;
      nAcc++;
    end else if (!rst) begin
      gapSeen = 1;
    end
    inA = 14'(a); inB = 14'(b); inValid = v;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0;
    @(negedge clk);
    modelClear();
    step(0, 0, 0, 0);
    check("R1 outValid", outValid, 0);
    check("R1 outA", outA, 0);
    check("R1 outB", outB, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    modelClear();
    repeat (3) @(negedge clk);
    doReset();

    // R9/R5: impulse into zero history, channels differ
    step(5000, -3000, 1);
    for (int i = 0; i < 6; i++) step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0);

    // R3/R4/R5: full ramp on A, mirrored ramp on B
    for (int v = -8192; v <= 8191; v++) step(v, -1 - v, 1);

    // R6/R7: random samples with random gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step($signed(lfsr[13:0]), $signed({lfsr[6:0], lfsr[13:7]}), lfsr[2] | lfsr[9]);
    end

    // R8: extremes, negative full scale lands on a tie
    for (int i = 0; i < 6; i++) step(8191, -8192, 1);
    for (int i = 0; i < 6; i++) step(-8192, 8191, 1);

    // R1/R9: reset in the middle of a stream, history restarts at zero
    for (int i = 0; i < 2; i++) step(4000, 4000, 1);
    doReset();
    for (int i = 0; i < 3; i++) step(-7000, 6000, 1);
    for (int i = 0; i < 8; i++) step(0, 0, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule